// File: doc/BRIEF.md
# Five-Bit Successive-Approximation Converter Controller

This block sequences a 5-bit successive-approximation conversion. Nothing outside the controller is modelled. A DAC code goes out to an external comparator. The comparator returns one bit saying whether the sampled analog level is at or above that code. The controller keeps or drops each trial bit, MSB first, and publishes the final code in a result register. It raises a completion flag when the result is ready.

Three sources can be converted: the two shared pins and a battery-sense tap. The source is chosen when a conversion starts and is driven to an analog multiplexer for the whole conversion. Each shared pin is set on its own to digital input or analog input. A digital read of a pin set to analog always returns 0.

With the default parameters and a 75 kHz clock, a conversion takes 96 clocks (1.28 ms). A code of 31 stands for 63/96 of the 3 V rail. That scaling belongs to the analog side and does not affect the digital behaviour.

Top module: `adc_sar_ctrl`

## Requirements
- R1: After reset, `busy`, `done`, `result`, `dac_code` and `mux_sel` are 0, and both pins are in digital mode, so `pin_rd` equals `pin_in`.
- R2: A conversion is accepted on a rising clock edge only if all three hold: `cmd_valid` is 1, `cmd_bits` is 2'b11, and `busy` is 0. Any other command value leaves the block idle.
- R3: A command that arrives while `busy` is 1 is ignored. The running conversion keeps its source and its finishing cycle.
- R4: An accepted start clears `done` on the same edge that sets `busy`.
- R5: The start is accepted at edge E0. At edge E(CONV_CLKS), which is edge 96 by default, `busy` falls and `done` rises. `busy` stays 1 for every cycle in between.
- R6: The conversion runs in slots of STEP = CONV_CLKS/BITS cycles, 19 by default, taken MSB first. During slot s, `dac_code` shows the bits already decided, plus a trial 1 at bit BITS-1-s. `cmp_hi` is sampled in the last cycle of the slot: 1 keeps the trial bit and 0 clears it. After the last slot, `dac_code` shows the final code.
- R7: When `done` rises, `result` holds the final code. It then stays unchanged until the next completion, whatever `cmp_hi` does.
- R8: `ch_sel` is captured at an accepted start and driven on `mux_sel`. The values are 0 for pin 0, 1 for pin 1 and 2 for the battery tap. A value of 3 selects the battery tap (2).
- R9: When `mode_we` is 1 at a clock edge, bit i of `mode_d` sets the mode of pin i: 0 for digital, 1 for analog. Each pin is set independently.
- R10: `pin_rd[i]` follows `pin_in[i]` when pin i is digital, and is 0 when pin i is analog. The output is combinational.
- R11: While `busy` is 0, `dac_code` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_bits | input | 2 | Command control bits; 2'b11 requests a conversion |
| ch_sel | input | 2 | Source to convert: 0 pin 0, 1 pin 1, 2 or 3 battery |
| mode_we | input | 1 | Write strobe for the pin modes |
| mode_d | input | 2 | Pin modes per bit: 0 digital, 1 analog |
| pin_in | input | 2 | Digital levels on the shared pins |
| pin_rd | output | 2 | Digital read of the pins, 0 for analog pins |
| cmp_hi | input | 1 | Comparator: analog level at or above `dac_code` |
| dac_code | output | 5 | Trial code to the DAC |
| mux_sel | output | 2 | Source driven to the analog multiplexer |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | Completion flag |
| result | output | 5 | Last converted code |

## Verification
Take the accepting edge as E0, and sample at the falling edge that follows each rising edge Ek. There, `dac_code` must match the slot arithmetic for cycle k, which is recomputed from k/19 in the bench. `busy` must be 1 for k from 0 to 95. `done` and `result` become valid only at k = 96. `done` must already be 0 at k = 0. A mode write is observed at the falling edge after its edge. `pin_rd` is combinational and is checked one time step after `pin_in` changes. The comparator model answers combinationally from `mux_sel` and `dac_code`, and the analog levels differ per source. So a wrongly latched source or a misplaced decision cycle shows up as a wrong trial code at a known k.

// File: rtl/adc_sar_pkg.sv
`timescale 1ns/1ps
package adc_sar_pkg;

  // analog source driven to the multiplexer
  typedef enum logic [1:0] {
    SRC_PIN0  = 2'd0,
    SRC_PIN1  = 2'd1,
    SRC_BATT  = 2'd2,
    SRC_SPARE = 2'd3
  } adc_src_e;

  // command value that requests a conversion
  localparam logic [1:0] GO_CODE = 2'b11;

  // the spare select value is folded onto the battery tap (R8)
  function automatic adc_src_e map_src(input logic [1:0] sel);
    if (sel == 2'd3) return SRC_BATT;
    return adc_src_e'(sel);
  endfunction

endpackage

// File: rtl/adc_pin_mode.sv
`timescale 1ns/1ps
module adc_pin_mode #(
  parameter int NPINS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_we,
  input  logic [NPINS-1:0] mode_d,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_mode,
  output logic [NPINS-1:0] pin_rd
);

  logic [NPINS-1:0] mode_q;

  // per-bit mode register: 0 digital, 1 analog (R9)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_we) mode_q <= mode_d;
  end

  assign pin_mode = mode_q;

  // an analog pin reads back as 0 (R10)
  for (genvar i = 0; i < NPINS; i++) begin : g_rd
    assign pin_rd[i] = mode_q[i] ? 1'b0 : pin_in[i];
  end

endmodule

// File: rtl/adc_sar_seq.sv
`timescale 1ns/1ps
module adc_sar_seq #(
  parameter int BITS      = 5,
  parameter int CONV_CLKS = 96
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic            cmp_hi,
  output logic [BITS-1:0] dac_code,
  output logic            busy,
  output logic            done,
  output logic [BITS-1:0] result,
  output logic            bit_sample,
  output logic            finish
);

  localparam int STEP = CONV_CLKS / BITS;
  localparam int CW   = $clog2(CONV_CLKS + 1);
  localparam int SUBW = (STEP > 1) ? $clog2(STEP) : 1;
  localparam int SW   = $clog2(BITS + 1);

  logic [CW-1:0]   cnt_q;
  logic [SUBW-1:0] sub_q;
  logic [SW-1:0]   slot_q;
  logic [BITS-1:0] sar_q, sar_d, result_q;
  logic            busy_q, done_q;

  // one-hot trial bit for slot s, MSB first; none once all slots are used
  function automatic logic [BITS-1:0] trial_mask(input logic [SW-1:0] s);
    logic [BITS-1:0] m;
    m = '0;
    for (int b = 0; b < BITS; b++)
      if (int'(s) == BITS - 1 - b) m[b] = 1'b1;
    return m;
  endfunction

  assign dac_code   = busy_q ? (sar_q | trial_mask(slot_q)) : '0;
  assign bit_sample = busy_q && (int'(slot_q) < BITS) && (int'(sub_q) == STEP - 1);
  assign finish     = busy_q && (int'(cnt_q) == CONV_CLKS - 1);
  assign sar_d      = (bit_sample && cmp_hi) ? dac_code : sar_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      sub_q    <= '0;
      slot_q   <= '0;
      sar_q    <= '0;
      result_q <= '0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
    end else if (go) begin
      cnt_q  <= '0;
      sub_q  <= '0;
      slot_q <= '0;
      sar_q  <= '0;
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
      sar_q <= sar_d;
      if (int'(sub_q) == STEP - 1) begin
        sub_q <= '0;
        if (int'(slot_q) < BITS) slot_q <= slot_q + 1'b1;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
      if (finish) begin
        busy_q   <= 1'b0;
        done_q   <= 1'b1;
        result_q <= sar_d;
      end
    end
  end

  assign busy   = busy_q;
  assign done   = done_q;
  assign result = result_q;

endmodule

// File: rtl/adc_sar_ctrl.sv
`timescale 1ns/1ps
module adc_sar_ctrl #(
  parameter int BITS      = 5,
  parameter int CONV_CLKS = 96,
  parameter int NPINS     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_bits,
  input  logic [1:0]       ch_sel,
  input  logic             mode_we,
  input  logic [NPINS-1:0] mode_d,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_rd,
  input  logic             cmp_hi,
  output logic [BITS-1:0]  dac_code,
  output logic [1:0]       mux_sel,
  output logic             busy,
  output logic             done,
  output logic [BITS-1:0]  result
);
  import adc_sar_pkg::*;

  logic             start_acc;
  logic             bit_sample;
  logic             finish;
  logic [NPINS-1:0] pin_mode;
  adc_src_e         src_q;

  // accepted start: strobe, go code and idle (R2, R3)
  assign start_acc = cmd_valid && (cmd_bits == GO_CODE) && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         src_q <= SRC_PIN0;
    else if (start_acc) src_q <= map_src(ch_sel);
  end
  assign mux_sel = src_q;

  adc_pin_mode #(.NPINS(NPINS)) u_pins (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_we  (mode_we),
    .mode_d   (mode_d),
    .pin_in   (pin_in),
    .pin_mode (pin_mode),
    .pin_rd   (pin_rd)
  );

  adc_sar_seq #(.BITS(BITS), .CONV_CLKS(CONV_CLKS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (start_acc),
    .cmp_hi     (cmp_hi),
    .dac_code   (dac_code),
    .busy       (busy),
    .done       (done),
    .result     (result),
    .bit_sample (bit_sample),
    .finish     (finish)
  );

endmodule

// File: rtl/adc_sar_ctrl_chk.sv
`timescale 1ns/1ps
module adc_sar_ctrl_chk #(
  parameter int BITS      = 5,
  parameter int CONV_CLKS = 96,
  parameter int NPINS     = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_acc,
  input logic             finish,
  input logic             busy,
  input logic             done,
  input logic [BITS-1:0]  result,
  input logic [BITS-1:0]  dac_code,
  input logic [1:0]       mux_sel,
  input logic [NPINS-1:0] pin_mode,
  input logic [NPINS-1:0] pin_rd
);

  // cycles spent busy since the last accepted start
  logic [15:0] ccnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                ccnt <= '0;
    else if (start_acc)        ccnt <= 16'd1;
    else if (busy && ccnt != '1) ccnt <= ccnt + 16'd1;
  end

  AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> (busy && !done)); // R4

  AST_CONV_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (int'(ccnt) == CONV_CLKS + 1)); // R5

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start_acc) |=> done); // R3

  AST_SOURCE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mux_sel)); // R8

  AST_SOURCE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    mux_sel != 2'd3); // R8

  AST_DAC_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (dac_code == '0)); // R11

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !finish |=> $stable(result)); // R7

  AST_ANALOG_READS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_mode & pin_rd) == '0); // R10

endmodule

bind adc_sar_ctrl adc_sar_ctrl_chk #(
  .BITS(BITS), .CONV_CLKS(CONV_CLKS), .NPINS(NPINS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_acc (start_acc),
  .finish    (finish),
  .busy      (busy),
  .done      (done),
  .result    (result),
  .dac_code  (dac_code),
  .mux_sel   (mux_sel),
  .pin_mode  (pin_mode),
  .pin_rd    (pin_rd)
);

// File: tb/adc_sar_ctrl_tb.sv
`timescale 1ns/1ps
module adc_sar_ctrl_tb;

  localparam int CONV = 96;
  localparam int STEP = 19;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_bits = 2'b00;
  logic [1:0] ch_sel = 2'b00;
  logic       mode_we = 1'b0;
  logic [1:0] mode_d = 2'b00;
  logic [1:0] pin_in = 2'b00;
  logic [1:0] pin_rd;
  logic       cmp_hi;
  logic [4:0] dac_code;
  logic [1:0] mux_sel;
  logic       busy, done;
  logic [4:0] result;
  logic [4:0] lvl [4];

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  // comparator model: level of the selected source against the trial code
  assign cmp_hi = (lvl[mux_sel] >= dac_code);

  adc_sar_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_bits(cmd_bits),
    .ch_sel(ch_sel), .mode_we(mode_we), .mode_d(mode_d), .pin_in(pin_in),
    .pin_rd(pin_rd), .cmp_hi(cmp_hi), .dac_code(dac_code), .mux_sel(mux_sel),
    .busy(busy), .done(done), .result(result)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // expected trial code k cycles after the accepting edge
  function automatic int exp_dac(input int v, input int k);
    int s = k / STEP;
    int hi;
    if (s >= 5) return v;
    hi = (v >> (5 - s)) << (5 - s);
    return hi | (1 << (4 - s));
  endfunction

  task automatic issue(input logic [1:0] code, input logic [1:0] ch);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_bits = code; ch_sel = ch;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // one full conversion of source ch at level v; intrude adds a start at k=40
  task automatic convert(input int ch, input int v, input bit intrude);
    int src = (ch == 3) ? 2 : ch;
    for (int i = 0; i < 4; i++) lvl[i] = 5'(31 - v);
    lvl[src] = 5'(v);
    issue(2'b11, 2'(ch));
    for (int k = 0; k <= CONV; k++) begin
      if (k == 0) chk(done == 1'b0, "R4 done cleared", int'(done), 0);
      chk(mux_sel == 2'(src), "R8 source latched", int'(mux_sel), src);
      if (k < CONV) begin
        chk(busy == 1'b1, "R5 busy", int'(busy), 1);
        chk(done == 1'b0, "R5 done early", int'(done), 0);
        chk(int'(dac_code) == exp_dac(v, k), "R6 trial code", int'(dac_code), exp_dac(v, k));
      end else begin
        chk(busy == 1'b0, "R5 busy end", int'(busy), 0);
        chk(done == 1'b1, "R5 done set", int'(done), 1);
        chk(int'(result) == v, "R7 result", int'(result), v);
        chk(dac_code == 5'd0, "R11 idle dac", int'(dac_code), 0);
      end
      if (intrude && k == 40) begin
        cmd_valid = 1'b1; cmd_bits = 2'b11; ch_sel = 2'((ch + 1) % 3);
      end else begin
        cmd_valid = 1'b0;
      end
      if (k < CONV) @(negedge clk);
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) lvl[i] = 5'd0;
    pin_in = 2'b10;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(done == 1'b0, "R1 done", int'(done), 0);
    chk(result == 5'd0, "R1 result", int'(result), 0);
    chk(dac_code == 5'd0, "R1 dac", int'(dac_code), 0);
    chk(mux_sel == 2'd0, "R1 mux", int'(mux_sel), 0);
    chk(pin_rd == pin_in, "R1 pins digital", int'(pin_rd), int'(pin_in));
    rst_n = 1'b1;
    @(negedge clk);

    // R2 rejected command values, including a strobe-less go code
    for (int c = 0; c < 3; c++) begin
      issue(2'(c), 2'd1);
      chk(busy == 1'b0, "R2 bad code ignored", int'(busy), 0);
      chk(mux_sel == 2'd0, "R2 source untouched", int'(mux_sel), 0);
    end
    @(negedge clk);
    cmd_bits = 2'b11;
    @(negedge clk);
    chk(busy == 1'b0, "R2 no strobe", int'(busy), 0);

    // R9 R10 all mode and pin combinations
    for (int m = 0; m < 4; m++) begin
      mode_d = 2'(m); mode_we = 1'b1;
      @(negedge clk);
      mode_we = 1'b0; mode_d = 2'(3 - m);
      @(negedge clk);
      for (int p = 0; p < 4; p++) begin
        pin_in = 2'(p);
        #1;
        chk(int'(pin_rd) == (p & ~m & 3), "R10 pin read", int'(pin_rd), p & ~m & 3);
      end
    end
    mode_d = 2'b01; mode_we = 1'b1;
    @(negedge clk);
    mode_we = 1'b0;

    // R6 R7 R8 sweep every level on every select value
    for (int ch = 0; ch < 4; ch++)
      for (int v = 0; v < 32; v++)
        convert(ch, v, 1'b0);

    // R7 result held while the comparator changes
    for (int i = 0; i < 4; i++) lvl[i] = 5'd7;
    repeat (5) @(negedge clk);
    chk(result == 5'd31, "R7 result held", int'(result), 31);
    chk(done == 1'b1, "R7 done held", int'(done), 1);

    // R3 start during a conversion is ignored
    convert(1, 21, 1'b1);
    convert(0, 10, 1'b1);

    // R9 mode kept through conversions
    pin_in = 2'b11;
    #1;
    chk(pin_rd == 2'b10, "R9 mode kept", int'(pin_rd), 2);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule